// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block holds the general-purpose registers of a small integer core. Two read ports each select any register and return its contents combinationally in the same cycle, so the operands of an instruction are ready as soon as its register numbers are. One write port stores a word on the rising clock edge when its write enable is high. Register 0 is hard-wired to zero.

A parameter chooses what a read returns when the same cycle also writes that register. In the old-value setting the read returns the stored contents and the new word lands at the edge, which is the ordering a single-cycle core needs. In the new-value setting the word being written is passed straight to the read port, which is the ordering a pipelined core needs when write-back and operand read fall in the same cycle. A synchronous clear input zeroes every register at the next edge and takes priority over a write in that cycle.

The asynchronous active-low reset is released inside the block through a short synchronizer. Every register is zero while reset is held and for the first two clock edges after release.

Top module: `regfile_2r1w`

## Requirements
- R1: After reset, every register reads as zero on both read ports.
- R2: When `wr_en` is 1 at a rising edge, `wr_data` is stored in the register `wr_addr` and is returned by either read port from the next cycle on.
- R3: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_addr` and `wr_data` hold.
- R4: The two read ports are independent. Each returns the register its own address selects, in the same cycle that the address is applied and with no clock edge in between.
- R5: With `RD_ORDER` = `RD_OLD` (0), a read of the register that the current cycle writes returns the value held before that write.
- R6: With `RD_ORDER` = `RD_NEW` (1), a read of the register that the current cycle writes returns `wr_data` in that same cycle.
- R7: Register 0 always reads as zero on both ports. A write to address 0 is dropped and is never forwarded.
- R8: When `clr` is 1 at a rising edge, every register becomes zero, even if a write is requested in the same cycle. While `clr` is 1, no write data is forwarded.
- R9: A write changes only the addressed register. All other registers keep their values.
- R10: Writes on the first two rising edges after `rst_n` goes high are ignored. Writes take effect from the third edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous clear of all registers; wins over a write |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Word to write |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Combinational read data, port A |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Combinational read data, port B |

## Verification
The hardest case to reach from the ports is a cycle that requests a write and a read of the same register while the clear is also asserted. Here the two ordering settings must agree: neither forwards, and the write is lost. The bench drives one copy of the block in each ordering setting from the same stimulus. It builds this collision on a register that holds a known non-zero value, then scans the whole file to confirm that the clear won. The window just after reset release is reached by asserting a write in the same step that `rst_n` rises, so that the writes fall on the two edges that the synchronizer swallows.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    RD_OLD = 1'b0,
    RD_NEW = 1'b1
  } rd_order_e;
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rf_wr_decoder.sv
module rf_wr_decoder #(
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [DEPTH-1:0]  wr_sel
);
  // Slot 0 has no storage, so its line is never enabled.
  assign wr_sel[0] = 1'b0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_line
    assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |-> ($countones(wr_sel) == 1 && wr_sel[wr_addr]));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_sel == '0));
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic [DEPTH-1:0]              wr_sel,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  regs_q
);
  assign regs_q[0] = '0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_entry
    logic              en;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    always_comb begin
      en = clr || wr_sel[i];
      d  = clr ? '0 : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign regs_q[i] = q;
  end

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (regs_q == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && wr_sel == '0) |=> $stable(regs_q));

  p_zero_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[0] == '0);
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int        DATA_W   = 32,
  parameter int        ADDR_W   = 5,
  parameter rd_order_e RD_ORDER = RD_OLD,
  localparam int       DEPTH    = 1 << ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] regs_q,
  input  logic                         fwd_valid,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data
);
  logic              hit;
  logic [DATA_W-1:0] stored;

  always_comb begin
    stored  = regs_q[rd_addr];
    hit     = fwd_valid && (wr_addr == rd_addr) && (rd_addr != '0);
    rd_data = (RD_ORDER == RD_NEW && hit) ? wr_data : stored;
  end

  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == '0) |-> (rd_data == '0));

  if (RD_ORDER == RD_NEW) begin : g_chk_new
    p_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (rd_data == wr_data));
  end else begin : g_chk_old
    p_oldval_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (rd_data == regs_q[wr_addr]));
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
  import rf_pkg::*;
#(
  parameter int        DATA_W     = 32,
  parameter int        ADDR_W     = 5,
  parameter rd_order_e RD_ORDER   = RD_OLD,
  parameter int        RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int N_PORTS = 2;

  logic                         rst_sync_n;
  logic [DEPTH-1:0]             wr_sel;
  logic [DEPTH-1:0][DATA_W-1:0] regs_q;
  logic                         fwd_valid;
  logic [ADDR_W-1:0]            port_addr [N_PORTS];
  logic [DATA_W-1:0]            port_data [N_PORTS];

  assign fwd_valid    = wr_en && !clr;
  assign port_addr[0] = rd_addr_a;
  assign port_addr[1] = rd_addr_b;
  assign rd_data_a    = port_data[0];
  assign rd_data_b    = port_data[1];

  rf_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rf_wr_decoder #(.ADDR_W(ADDR_W)) u_wr_decoder (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_sel  (wr_sel)
  );

  rf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_storage (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (clr),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    rf_read_port #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .RD_ORDER (RD_ORDER)
    ) u_read_port (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .rd_addr   (port_addr[p]),
      .regs_q    (regs_q),
      .fwd_valid (fwd_valid),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_data   (port_data[p])
    );
  end

  p_written_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !clr && wr_addr != '0) |=> (regs_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: tb/regfile_2r1w_bench.sv
module regfile_2r1w_bench;
  import rf_pkg::*;

  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int AW    = 5;
  localparam int NREG  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd_addr_a;
  logic [AW-1:0] rd_addr_b;
  logic [DW-1:0] rd_data_a;
  logic [DW-1:0] rd_data_b;
  logic [DW-1:0] rd_data_a_f;
  logic [DW-1:0] rd_data_b_f;

  always #(CLK_P/2) clk = ~clk;

  regfile_2r1w #(.DATA_W(DW), .ADDR_W(AW), .RD_ORDER(RD_OLD)) u_regfile_2r1w (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
  );

  regfile_2r1w #(.DATA_W(DW), .ADDR_W(AW), .RD_ORDER(RD_NEW)) u_regfile_2r1w_fwd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a_f),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b_f)
  );

  typedef struct {
    string         req;
    int            port;
    logic [DW-1:0] exp;
  } item_t;

  item_t         sb_q[$];
  logic [DW-1:0] mdl [NREG];
  int            n_chk = 0;
  int            n_err = 0;
  bit            done  = 1'b0;

  task automatic push(input string req, input int port, input logic [DW-1:0] e);
    item_t it;
    it.req  = req;
    it.port = port;
    it.exp  = e;
    sb_q.push_back(it);
  endtask

  // Drives one cycle, queues what each port must show, then advances the model.
  task automatic cyc(input bit w, input int wa, input logic [DW-1:0] wd,
                     input int ra, input int rb, input bit c, input bit live,
                     input string req);
    wr_en     = w;
    wr_addr   = AW'(wa);
    wr_data   = wd;
    rd_addr_a = AW'(ra);
    rd_addr_b = AW'(rb);
    clr       = c;
    for (int p = 0; p < 2; p++) begin
      int            a;
      bit            hit;
      logic [DW-1:0] old;
      string         rq_old;
      string         rq_new;
      a      = (p == 0) ? ra : rb;
      old    = (a == 0) ? '0 : mdl[a];
      hit    = w && !c && (wa == a) && (a != 0);
      rq_old = (a == 0) ? "R7" : (hit ? "R5" : req);
      rq_new = (a == 0) ? "R7" : (hit ? "R6" : req);
      push(rq_old, p, old);
      push(rq_new, p + 2, hit ? wd : old);
    end
    if (live) begin
      if (c) begin
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
      end else if (w && wa != 0) begin
        mdl[wa] = wd;
      end
    end
    @(negedge clk);
  endtask

  // Monitor: compares queued expectations a quarter period after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb_q.size() > 0) begin
        item_t         it;
        logic [DW-1:0] act;
        it = sb_q.pop_front();
        case (it.port)
          0:       act = rd_data_a;
          1:       act = rd_data_b;
          2:       act = rd_data_a_f;
          default: act = rd_data_b_f;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s port %0d: actual=%h expected=%h", it.req, it.port, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_err++;
      $display("FAIL all: watchdog expired, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);

    // R10: writes on the two edges right after release are swallowed.
    rst_n = 1'b1;
    cyc(1, 5, 32'h5555_AAAA, 1, 2, 0, 0, "R10");
    cyc(1, 6, 32'h6666_BBBB, 3, 4, 0, 0, "R10");
    cyc(0, 0, '0, 5, 6, 0, 1, "R10");

    // R1: whole file is zero after reset.
    for (int i = 0; i < NREG/2; i++) cyc(0, 0, '0, i, i + NREG/2, 0, 1, "R1");

    // R2 with same-cycle reads (R5 / R6) on port A, previous register on port B.
    for (int i = 1; i < NREG; i++)
      cyc(1, i, 32'hA500_0000 ^ (i * 32'h0101_0101), i, i - 1, 0, 1, "R2");

    // R4: both ports read different registers each cycle.
    for (int i = 0; i < NREG/2; i++) cyc(0, 0, '0, i, NREG - 1 - i, 0, 1, "R4");

    // R3: disabled write is ignored.
    cyc(0, 3, 32'hDEAD_BEEF, 7, 3, 0, 1, "R3");
    cyc(0, 0, '0, 3, 3, 0, 1, "R3");

    // R7: register 0 is never written or forwarded.
    cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 1, "R7");
    cyc(0, 0, '0, 0, 1, 0, 1, "R7");

    // R9: neighbours of a written register keep their values.
    cyc(1, 9, 32'h1234_5678, 8, 10, 0, 1, "R9");
    cyc(0, 0, '0, 9, 10, 0, 1, "R9");
    cyc(0, 0, '0, 8, 9, 0, 1, "R9");

    // R8: clear collides with a write and a read of the same register.
    cyc(1, 4, 32'hCAFE_F00D, 4, 12, 1, 1, "R8");
    for (int i = 0; i < NREG/2; i++) cyc(0, 0, '0, i, i + NREG/2, 0, 1, "R8");

    // R2: writes work again after the clear.
    cyc(1, 4, 32'h0BAD_CAFE, 4, 4, 0, 1, "R2");
    cyc(0, 0, '0, 4, 5, 0, 1, "R2");

    @(negedge clk);
    #(CLK_P/2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule